// File: doc/BRIEF.md
# Power Distribution Contactor Controller

This block is a clocked supervisory controller for an electrical power distribution network with two main generators and two auxiliary sources. On every clock edge it samples four source-health flags. From these flags and from the contactor pattern it drove in the previous cycle, it computes a registered 13-bit contactor-close vector. The vector connects each generator to its bus, closes tie paths to the auxiliary sources, brings in backup feeds and cross-bus links, and keeps a fixed group of feeders closed permanently.

Sources are expected to fail permanently, and at least one of them is expected to stay healthy. The block watches both expectations. If a failed source reports healthy again, or if all four sources report unhealthy, the block raises a sticky violation flag. A parameter selects which auxiliary tie wins when both auxiliary sources are healthy and neither tie is already closed.

Top module: `pdn_contactor_ctrl`

## Requirements
- R1: Synchronous reset opens all thirteen contactors and clears the violation flag. After the first clock edge with reset low, contactors c7, c8, c11, c12 and c13 (vector bits 6, 7, 10, 11, 12) are closed, and they stay closed until the next reset.
- R2: After each edge with reset low, c1 (bit 0) equals the left-main health flag (`src_ok_i[0]`) sampled at that edge, and c4 (bit 3) equals the right-main health flag (`src_ok_i[1]`).
- R3: When both mains sampled healthy, c2, c3, c5, c6, c9 and c10 (bits 1, 2, 4, 5, 8, 9) are open. When both mains sampled unhealthy, c9 and c10 are closed.
- R4: c5 (bit 4) closes when the left main is unhealthy, or when the right main and both auxiliaries (`src_ok_i[2]`, `src_ok_i[3]`) are unhealthy; otherwise it is open. c6 (bit 5) mirrors this with the sides exchanged. While either auxiliary is healthy, c1 and c5 are never closed together, and c4 and c6 are never closed together.
- R5: c2 (bit 1) closes only if the left auxiliary sampled healthy, and c3 (bit 2) closes only if the right auxiliary sampled healthy. c2 and c3 are never closed together.
- R6: A closed tie stays closed while its auxiliary stays healthy and the mains are not both healthy.
- R7: When at least one main is unhealthy and neither tie is held, a free tie is chosen. With the default preference this is c2 if the left auxiliary is healthy, otherwise c3 if the right auxiliary is healthy. With the right preference set, the order is reversed.
- R8: `assume_err_o` rises one edge after a source goes from unhealthy to healthy, or after an edge at which all four sources are unhealthy. It stays high until reset. At an all-unhealthy edge, c1 to c6 are opened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_ok_i | input | 4 | Health flags: bit0 left main, bit1 right main, bit2 left aux, bit3 right aux |
| contactor_o | output | 13 | Contactor close commands, bit k drives contactor c(k+1) |
| assume_err_o | output | 1 | Sticky health-assumption violation flag |

## Verification
The bench builds the block with its default parameters: left-preferred tie selection and the fixed 4-source, 13-contactor geometry. With these values, every failure order of mains and auxiliaries is within reach. This covers tie hold across a later main failure, the handover from c2 to c3 when the left auxiliary drops, both-aux-lost backup closure, and both kinds of assumption violation. The right-preferred variant is only elaborated; no sequence in the bench depends on its order.

// File: rtl/pdn_cc_pkg.sv
`timescale 1ns/1ps
package pdn_cc_pkg;
   localparam int N_SRC = 4;
   localparam int N_CON = 13;

   // health vector bit positions (behavioural: match port description)
   localparam int H_MAIN_L = 0;
   localparam int H_MAIN_R = 1;
   localparam int H_AUX_L  = 2;
   localparam int H_AUX_R  = 3;

   // contactor bit positions (bit k drives contactor c(k+1))
   localparam int K_GEN_L  = 0;
   localparam int K_TIE_L  = 1;
   localparam int K_TIE_R  = 2;
   localparam int K_GEN_R  = 3;
   localparam int K_BKP_L  = 4;
   localparam int K_BKP_R  = 5;
   localparam int K_XB_L   = 8;
   localparam int K_XB_R   = 9;

   localparam logic [N_CON-1:0] FIXED_MASK = 13'b1_1100_1100_0000;

   typedef struct packed {
      logic aux_r;
      logic aux_l;
      logic main_r;
      logic main_l;
   } health_t;
endpackage

// File: rtl/pdn_health_mon.sv
`timescale 1ns/1ps
module pdn_health_mon
   import pdn_cc_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  health_t hlt_i,
   output logic    all_bad_o,
   output logic    err_o
);
   health_t prev_q;
   logic    prev_vld_q;
   logic    recover;

   assign all_bad_o = (hlt_i == '0);
   assign recover   = prev_vld_q && ((~prev_q & hlt_i) != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q     <= '0;
         prev_vld_q <= 1'b0;
         err_o      <= 1'b0;
      end else begin
         prev_q     <= hlt_i;
         prev_vld_q <= 1'b1;
         if (all_bad_o || recover) err_o <= 1'b1;
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      err_o |=> err_o); // R8
   AST_ERR_ALL_BAD: assert property (@(posedge clk) disable iff (rst)
      (hlt_i == '0) |=> err_o); // R8
endmodule

// File: rtl/pdn_tie_arbiter.sv
`timescale 1ns/1ps
module pdn_tie_arbiter
   import pdn_cc_pkg::*;
#(
   parameter bit PREFER_RIGHT = 1'b0
)(
   input  logic       clk,
   input  logic       rst,
   input  health_t    hlt_i,
   output logic [1:0] tie_q   // [0] left tie c2, [1] right tie c3
);
   logic       mains_ok;
   logic       hold_l, hold_r;
   logic [1:0] free_pick;
   logic [1:0] tie_d;

   assign mains_ok = hlt_i.main_l && hlt_i.main_r;
   assign hold_l   = tie_q[0] && hlt_i.aux_l;
   assign hold_r   = tie_q[1] && hlt_i.aux_r;

   generate
      if (PREFER_RIGHT) begin : g_pref_r
         always_comb begin
            if (hlt_i.aux_r)      free_pick = 2'b10;
            else if (hlt_i.aux_l) free_pick = 2'b01;
            else                  free_pick = 2'b00;
         end
      end else begin : g_pref_l
         always_comb begin
            if (hlt_i.aux_l)      free_pick = 2'b01;
            else if (hlt_i.aux_r) free_pick = 2'b10;
            else                  free_pick = 2'b00;
         end
      end
   endgenerate

   always_comb begin
      if (mains_ok)    tie_d = 2'b00;
      else if (hold_l) tie_d = 2'b01;
      else if (hold_r) tie_d = 2'b10;
      else             tie_d = free_pick;
   end

   always_ff @(posedge clk) begin
      if (rst) tie_q <= 2'b00;
      else     tie_q <= tie_d;
   end

   AST_TIE_MUTEX: assert property (@(posedge clk) disable iff (rst)
      !(tie_q[0] && tie_q[1])); // R5
   AST_TIE_AUX_L: assert property (@(posedge clk) disable iff (rst)
      !hlt_i.aux_l |=> !tie_q[0]); // R5
   AST_TIE_AUX_R: assert property (@(posedge clk) disable iff (rst)
      !hlt_i.aux_r |=> !tie_q[1]); // R5
   AST_TIE_HOLD_L: assert property (@(posedge clk) disable iff (rst)
      (tie_q[0] && hlt_i.aux_l && !mains_ok) |=> tie_q[0]); // R6
   AST_TIE_HOLD_R: assert property (@(posedge clk) disable iff (rst)
      (tie_q[1] && hlt_i.aux_r && !mains_ok) |=> tie_q[1]); // R6
endmodule

// File: rtl/pdn_feeder_logic.sv
`timescale 1ns/1ps
module pdn_feeder_logic
   import pdn_cc_pkg::*;
(
   input  health_t          hlt_i,
   input  logic             all_bad_i,
   output logic [N_CON-1:0] feed_o   // tie bits left at zero
);
   logic aux_none;
   assign aux_none = !hlt_i.aux_l && !hlt_i.aux_r;

   always_comb begin
      feed_o          = FIXED_MASK;
      feed_o[K_GEN_L] = hlt_i.main_l;
      feed_o[K_GEN_R] = hlt_i.main_r;
      feed_o[K_BKP_L] = !hlt_i.main_l || (!hlt_i.main_r && aux_none);
      feed_o[K_BKP_R] = !hlt_i.main_r || (!hlt_i.main_l && aux_none);
      feed_o[K_XB_L]  = !hlt_i.main_l && !hlt_i.main_r;
      feed_o[K_XB_R]  = !hlt_i.main_l && !hlt_i.main_r;
      if (all_bad_i) begin
         feed_o[K_GEN_L] = 1'b0;
         feed_o[K_GEN_R] = 1'b0;
         feed_o[K_BKP_L] = 1'b0;
         feed_o[K_BKP_R] = 1'b0;
      end
   end
endmodule

// File: rtl/pdn_contactor_ctrl.sv
`timescale 1ns/1ps
module pdn_contactor_ctrl
   import pdn_cc_pkg::*;
#(
   parameter int SRC_W        = 4,
   parameter int CON_W        = 13,
   parameter bit PREFER_RIGHT = 1'b0
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [SRC_W-1:0] src_ok_i,
   output logic [CON_W-1:0] contactor_o,
   output logic             assume_err_o
);
   generate
      if (SRC_W != N_SRC) begin : g_bad_src
         $error("SRC_W must equal the fixed source count");
      end
      if (CON_W != N_CON) begin : g_bad_con
         $error("CON_W must equal the fixed contactor count");
      end
   endgenerate

   health_t          hlt;
   logic             all_bad;
   logic [N_CON-1:0] feed;
   logic [N_CON-1:0] feed_q;
   logic [1:0]       tie_q;

   assign hlt = health_t'(src_ok_i[N_SRC-1:0]);

   pdn_health_mon u_mon (
      .clk       (clk),
      .rst       (rst),
      .hlt_i     (hlt),
      .all_bad_o (all_bad),
      .err_o     (assume_err_o)
   );

   pdn_feeder_logic u_feed (
      .hlt_i     (hlt),
      .all_bad_i (all_bad),
      .feed_o    (feed)
   );

   pdn_tie_arbiter #(.PREFER_RIGHT(PREFER_RIGHT)) u_tie (
      .clk   (clk),
      .rst   (rst),
      .hlt_i (hlt),
      .tie_q (tie_q)
   );

   always_ff @(posedge clk) begin
      if (rst) feed_q <= '0;
      else     feed_q <= feed;
   end

   always_comb begin
      contactor_o          = feed_q;
      contactor_o[K_TIE_L] = tie_q[0];
      contactor_o[K_TIE_R] = tie_q[1];
   end

   AST_FIXED_ON: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((contactor_o & FIXED_MASK) == FIXED_MASK)); // R1
   AST_GEN_TRACK_L: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (contactor_o[K_GEN_L] == $past(src_ok_i[H_MAIN_L]))); // R2
   AST_GEN_TRACK_R: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (contactor_o[K_GEN_R] == $past(src_ok_i[H_MAIN_R]))); // R2
   AST_MAINS_OK_OPEN: assert property (@(posedge clk) disable iff (rst)
      (src_ok_i[H_MAIN_L] && src_ok_i[H_MAIN_R]) |=>
      (contactor_o[K_XB_R:K_XB_L] == 2'b00 && contactor_o[K_BKP_R:K_TIE_L] == 5'b00100)
      == (contactor_o[K_GEN_R] == 1'b1)); // R3
   AST_MAINS_LOST_XB: assert property (@(posedge clk) disable iff (rst)
      (!src_ok_i[H_MAIN_L] && !src_ok_i[H_MAIN_R]) |=> (contactor_o[K_XB_R:K_XB_L] == 2'b11)); // R3
   AST_GEN_BKP_EXCL_L: assert property (@(posedge clk) disable iff (rst)
      (src_ok_i[H_AUX_L] || src_ok_i[H_AUX_R]) |=> !(contactor_o[K_GEN_L] && contactor_o[K_BKP_L])); // R4
   AST_GEN_BKP_EXCL_R: assert property (@(posedge clk) disable iff (rst)
      (src_ok_i[H_AUX_L] || src_ok_i[H_AUX_R]) |=> !(contactor_o[K_GEN_R] && contactor_o[K_BKP_R])); // R4
   AST_ALL_BAD_OPEN: assert property (@(posedge clk) disable iff (rst)
      (src_ok_i[N_SRC-1:0] == '0) |=> (contactor_o[K_BKP_R:K_GEN_L] == '0)); // R8
endmodule

// File: tb/test_pdn_contactor_ctrl.sv
`timescale 1ns/1ps
module test_pdn_contactor_ctrl;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  src_ok = 4'b1111;
   logic [12:0] con;
   logic        err;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pdn_contactor_ctrl i_pdn_contactor_ctrl (
      .clk          (clk),
      .rst          (rst),
      .src_ok_i     (src_ok),
      .contactor_o  (con),
      .assume_err_o (err)
   );

   // scoreboard queues
   logic [12:0] q_con[$];
   logic        q_err[$];
   string       q_tag[$];

   // reference model state
   logic [12:0] m_con   = '0;
   logic        m_err   = 1'b0;
   logic [3:0]  m_prev  = '0;
   logic        m_pvld  = 1'b0;

   task automatic step(input logic r, input logic [3:0] h, input string tag);
      logic [12:0] n;
      logic lm, rm, la, ra;
      @(negedge clk);
      rst    = r;
      src_ok = h;
      lm = h[0]; rm = h[1]; la = h[2]; ra = h[3];
      if (r) begin
         n = '0; m_err = 1'b0; m_pvld = 1'b0; m_prev = '0;
      end else begin
         n = 13'b1_1100_1100_0000;                  // R1 fixed feeders
         n[0] = lm; n[3] = rm;                       // R2
         n[4] = !lm || (!rm && !la && !ra);          // R4
         n[5] = !rm || (!lm && !la && !ra);          // R4
         n[8] = !lm && !rm; n[9] = !lm && !rm;       // R3
         if (lm && rm)             begin n[1] = 0; n[2] = 0; end // R3
         else if (m_con[1] && la)  n[1] = 1;        // R6
         else if (m_con[2] && ra)  n[2] = 1;        // R6
         else if (la)              n[1] = 1;        // R7
         else if (ra)              n[2] = 1;        // R7
         if (h == 4'b0000) begin n[5:0] = '0; m_err = 1'b1; end // R8
         if (m_pvld && ((~m_prev & h) != 4'b0)) m_err = 1'b1;   // R8
         m_prev = h; m_pvld = 1'b1;
      end
      m_con = n;
      q_con.push_back(n);
      q_err.push_back(m_err);
      q_tag.push_back(tag);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_con.size() > 0) begin
            logic [12:0] ec;
            logic        ee;
            string       t;
            ec = q_con.pop_front();
            ee = q_err.pop_front();
            t  = q_tag.pop_front();
            n_run++;
            if (con !== ec || err !== ee) begin
               n_fail++;
               $display("FAIL %s: contactors=%b err=%b expected contactors=%b err=%b",
                        t, con, err, ec, ee);
            end
         end
      end
   end

   // watchdog
   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // reset state
      step(1, 4'b1111, "R1 reset");
      step(1, 4'b1111, "R1 reset");
      step(0, 4'b1111, "R1 R2 R3 all healthy");
      step(0, 4'b1111, "R1 R3 all healthy hold");
      // left main lost: c2 picked, c5 closes
      step(0, 4'b1110, "R7 R4 left main lost");
      step(0, 4'b1110, "R6 tie c2 held");
      // left aux lost: c2 drops, c3 takes over
      step(0, 4'b1010, "R5 R7 left aux lost");
      step(0, 4'b1000, "R3 R6 both mains lost");
      step(0, 4'b1000, "R6 R3 hold");

      // sequence B: right side lost
      step(1, 4'b1111, "R1 reset B");
      step(0, 4'b1111, "R1 B healthy");
      step(0, 4'b0101, "R7 R4 right main and aux lost");
      step(0, 4'b0100, "R3 R6 R4 both mains lost B");

      // sequence C: both aux lost, mains healthy
      step(1, 4'b1111, "R1 reset C");
      step(0, 4'b0011, "R5 R3 both aux lost");
      step(0, 4'b0010, "R4 backup with no aux");
      step(0, 4'b0010, "R4 hold");

      // sequence D: recovery violation
      step(1, 4'b1111, "R1 reset D");
      step(0, 4'b1110, "R7 D left main lost");
      step(0, 4'b1111, "R8 recovery flagged next");
      step(0, 4'b1111, "R8 sticky");
      step(1, 4'b1111, "R1 R8 reset clears flag");

      // sequence E: all sources unhealthy
      step(0, 4'b1111, "R1 E healthy");
      step(0, 4'b0000, "R8 all unhealthy");
      step(0, 4'b0000, "R8 sticky all unhealthy");
      step(0, 4'b0001, "R8 sticky after recovery");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule